// File: doc/BRIEF.md
# Seconds-Granular Watchdog Timer with Expiry Status

This block is a watchdog timer that sits inside a configuration register file. Software reaches it through a small register interface with three registers: a count register, a control register and a status register. Writing a nonzero value to the count register loads the countdown and starts it. Writing the same kind of value again while the countdown runs restarts it, and this is the keep-alive. Writing zero stops the timer. Reading the count register returns the time that is left.

A prescaler divides the clock down to one-second ticks. In minute mode, a second stage turns those into one-minute ticks. When the count runs out, the block latches a sticky expiry flag. If the control register allows it, the block also drives an active-low pulse of fixed length on a keyboard-reset output. Two activity inputs can restart a running countdown, each through its own enable. One input comes from the keyboard and one from the mouse. Each restart reloads the last nonzero value that software wrote.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, all three registers read 0 and `kbRstN` is 1. Address 0 is the count register, address 1 is the control register and address 2 is the status register. Address 3 reads 0 and ignores writes.
- R2: A nonzero write to the count register takes effect at the next edge, and the value reads back. In seconds mode (control bit 3 = 0), the count then drops by one every `CLK_PER_SEC` cycles.
- R3: Writing 0 to the count register stops the timer. The count then stays 0, no expiry occurs and `kbRstN` stays 1.
- R4: A nonzero count write while the timer is running reloads the count and restarts the prescaler, so the next decrement comes a full `CLK_PER_SEC` cycles after that write.
- R5: With control bit 3 set (minute mode), the count drops by one every `SEC_PER_MIN*CLK_PER_SEC` cycles.
- R6: When a decrement takes the count from 1 to 0, status bit 4 is set at that same edge. The count then stays 0 until it is written again.
- R7: If control bit 1 is set when the timer expires, `kbRstN` goes low for exactly `PULSE_CYCLES` cycles, starting at the expiry edge. If bit 1 is clear, `kbRstN` stays 1.
- R8: Status bit 4 stays set through count writes and reloads. It is cleared only by a status write with bit 4 = 0 or by reset. Writing 1 to it has no effect. An expiry in the same cycle as a clear leaves it set.
- R9: A one-cycle `kbdAct` pulse during a running countdown reloads the last nonzero written value and restarts the prescaler. This happens only when control bit 2 and status bit 6 are both set. Otherwise the pulse has no effect.
- R10: A one-cycle `mouseAct` pulse during a running countdown reloads the last nonzero written value when status bit 7 is set. Otherwise the pulse has no effect.
- R11: Activity pulses while the count is 0 leave the count at 0.
- R12: Status bits 7 and 6 are read/write. The other status bits, apart from bit 4, read 0. The control register stores and returns all 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select for reads and writes |
| regWr | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| kbdAct | input | 1 | Keyboard activity pulse |
| mouseAct | input | 1 | Mouse activity pulse |
| kbRstN | output | 1 | Active-low expiry pulse toward the keyboard-reset line |

## Verification
The hardest situations to reach from the ports are the collisions on one edge. Examples are an expiry in the same cycle as a status clear, an activity reload in the same cycle as the last decrement, and a count write that lands on a prescaler wrap. Directed tests cannot place these easily. The bench therefore runs a long random phase with small count values and a short prescaler, so expiries happen often. In that phase it drives writes, activity pulses and enable changes at random. Every cycle it compares the register readback and `kbRstN` against a cycle model written from the requirements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 8;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;

  localparam int CTRL_PULSE_BIT = 1;
  localparam int CTRL_KBD_BIT   = 2;
  localparam int CTRL_MIN_BIT   = 3;
  localparam int STAT_FLAG_BIT  = 4;
  localparam int STAT_KBD_BIT   = 6;
  localparam int STAT_MOUSE_BIT = 7;

  // strobes from the register side into the counting datapath
  typedef struct packed {
    logic             load;       // load loadVal and restart prescaler
    logic [CNT_W-1:0] loadVal;    // 0 stops the timer
    logic             minuteMode;
    logic             pulseEn;
  } wdog_cmd_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CLK_PER_SEC  = 32768,
  parameter int SEC_PER_MIN  = 60,
  parameter int PULSE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdog_cmd_t        cmd,
  output logic [CNT_W-1:0] cntVal,
  output logic             expire,
  output logic             kbRstN
);
  localparam int PRE_W = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam int MIN_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int PUL_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_SEC - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(SEC_PER_MIN - 1);
  localparam logic [PUL_W-1:0] PUL_LEN  = PUL_W'(PULSE_CYCLES);

  logic [PRE_W-1:0] preCnt;
  logic [MIN_W-1:0] minCnt;
  logic [PUL_W-1:0] pulseCnt;
  logic running, secTick, lastSec, unitTick;

  assign running  = (cntVal != '0);
  assign secTick  = running && (preCnt == PRE_LAST);
  assign lastSec  = !cmd.minuteMode || (minCnt == MIN_LAST);
  assign unitTick = secTick && lastSec;
  assign expire   = !cmd.load && unitTick && (cntVal == CNT_W'(1));

  // prescaler and countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
      preCnt <= '0;
      minCnt <= '0;
    end else if (cmd.load) begin
      cntVal <= cmd.loadVal;
      preCnt <= '0;
      minCnt <= '0;
    end else if (running) begin
      preCnt <= secTick ? '0 : preCnt + 1'b1;
      if (secTick) begin
        if (cmd.minuteMode) minCnt <= (minCnt == MIN_LAST) ? '0 : minCnt + 1'b1;
        else                minCnt <= '0;
      end
      if (unitTick) cntVal <= cntVal - 1'b1;
    end
  end

  // expiry pulse stretcher
  always_ff @(posedge clk) begin
    if (!rstN)                      pulseCnt <= '0;
    else if (expire && cmd.pulseEn) pulseCnt <= PUL_LEN;
    else if (pulseCnt != '0)        pulseCnt <= pulseCnt - 1'b1;
  end

  assign kbRstN = (pulseCnt == '0);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             kbdAct,
  input  logic             mouseAct,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             expire,
  output wdog_cmd_t        cmd
);
  logic [7:0]       ctrlReg;
  logic             kbdEn, mouseEn, statusFlag;
  logic [CNT_W-1:0] reloadVal;
  logic cntWr, ctrlWr, statWr, running, actHit;

  assign cntWr   = regWr && (regAddr == ADDR_COUNT);
  assign ctrlWr  = regWr && (regAddr == ADDR_CTRL);
  assign statWr  = regWr && (regAddr == ADDR_STAT);
  assign running = (cntVal != '0);
  assign actHit  = running &&
                   ((kbdAct && ctrlReg[CTRL_KBD_BIT] && kbdEn) ||
                    (mouseAct && mouseEn));

  always_comb begin
    cmd.load       = cntWr || actHit;
    cmd.loadVal    = cntWr ? regWrData : reloadVal;
    cmd.minuteMode = ctrlReg[CTRL_MIN_BIT];
    cmd.pulseEn    = ctrlReg[CTRL_PULSE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      kbdEn     <= 1'b0;
      mouseEn   <= 1'b0;
      reloadVal <= '0;
    end else begin
      if (ctrlWr) ctrlReg <= regWrData;
      if (statWr) begin
        kbdEn   <= regWrData[STAT_KBD_BIT];
        mouseEn <= regWrData[STAT_MOUSE_BIT];
      end
      if (cntWr && (regWrData != '0)) reloadVal <= regWrData;
    end
  end

  // sticky expiry flag: set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)                                    statusFlag <= 1'b0;
    else if (expire)                              statusFlag <= 1'b1;
    else if (statWr && !regWrData[STAT_FLAG_BIT]) statusFlag <= 1'b0;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_COUNT: regRdData = cntVal;
      ADDR_CTRL:  regRdData = ctrlReg;
      ADDR_STAT: begin
        regRdData[STAT_MOUSE_BIT] = mouseEn;
        regRdData[STAT_KBD_BIT]   = kbdEn;
        regRdData[STAT_FLAG_BIT]  = statusFlag;
      end
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import wdog_pkg::*;
#(
  parameter int CLK_PER_SEC  = 32768,
  parameter int SEC_PER_MIN  = 60,
  parameter int PULSE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       kbdAct,
  input  logic       mouseAct,
  output logic       kbRstN
);
  wdog_cmd_t        cmd;
  logic [CNT_W-1:0] cntVal;
  logic             expire;

  wdog_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .kbdAct(kbdAct),
    .mouseAct(mouseAct), .cntVal(cntVal), .expire(expire), .cmd(cmd)
  );

  wdog_datapath #(
    .CLK_PER_SEC(CLK_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) dpI (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntVal(cntVal),
    .expire(expire), .kbRstN(kbRstN)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regAddr,
  input logic       regWr,
  input logic [7:0] regWrData,
  input logic       kbRstN,
  input logic [7:0] cntVal,
  input logic       load,
  input logic       expire,
  input logic       pulseEn,
  input logic       statFlag
);
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0) |=> (cntVal == $past(regWrData))); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!load && cntVal != 8'd0) |=>
      (cntVal == $past(cntVal) || cntVal == $past(cntVal) - 8'd1)); // R2

  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0 && regWrData == 8'd0) |=> (cntVal == 8'd0)); // R3

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == 8'd0 && !load) |=> (cntVal == 8'd0)); // R6

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> statFlag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statFlag && !(regWr && regAddr == 2'd2 && !regWrData[4])) |=> statFlag); // R8

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (expire && pulseEn) |=> !kbRstN); // R7

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kbRstN) |-> $past(expire && pulseEn)); // R7
endmodule

bind sec_watchdog wdog_checker chkI (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
  .regWrData(regWrData), .kbRstN(kbRstN), .cntVal(cntVal),
  .load(cmd.load), .expire(expire), .pulseEn(cmd.pulseEn),
  .statFlag(ctrlI.statusFlag)
);

// File: tb/sec_watchdog_tb.sv
module sec_watchdog_tb_top;
  localparam int CPS = 8;
  localparam int SPM = 60;
  localparam int PUL = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       kbdAct = 1'b0;
  logic       mouseAct = 1'b0;
  logic       kbRstN;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sec_watchdog #(.CLK_PER_SEC(CPS), .SEC_PER_MIN(SPM), .PULSE_CYCLES(PUL)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .kbdAct(kbdAct),
    .mouseAct(mouseAct), .kbRstN(kbRstN)
  );

  // ---------------- cycle model built from the requirements ----------------
  logic [7:0] mCnt, mReload, mCtrl;
  int         mPre, mMin, mPulse;
  logic       mStat, mKbdEn, mMouEn;
  logic       mRun, mAct, mTick, mExp, mClr;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt <= 0; mReload <= 0; mCtrl <= 0; mPre <= 0; mMin <= 0;
      mPulse <= 0; mStat <= 0; mKbdEn <= 0; mMouEn <= 0;
    end else begin
      mRun  = (mCnt != 0);
      mAct  = mRun && ((kbdAct && mCtrl[2] && mKbdEn) || (mouseAct && mMouEn));
      mTick = mRun && (mPre == CPS-1) && (!mCtrl[3] || mMin == SPM-1);
      mExp  = 1'b0;
      if (regWr && regAddr == 2'd0) begin
        mCnt <= regWrData; mPre <= 0; mMin <= 0;
        if (regWrData != 0) mReload <= regWrData;
      end else if (mAct) begin
        mCnt <= mReload; mPre <= 0; mMin <= 0;
      end else if (mRun) begin
        mPre <= (mPre == CPS-1) ? 0 : mPre + 1;
        if (mPre == CPS-1) mMin <= mCtrl[3] ? ((mMin == SPM-1) ? 0 : mMin + 1) : 0;
        if (mTick) begin
          mCnt <= mCnt - 8'd1;
          mExp = (mCnt == 8'd1);
        end
      end
      mClr = regWr && regAddr == 2'd2 && !regWrData[4];
      if (mExp) mStat <= 1'b1;
      else if (mClr) mStat <= 1'b0;
      if (regWr && regAddr == 2'd2) begin
        mKbdEn <= regWrData[6]; mMouEn <= regWrData[7];
      end
      if (regWr && regAddr == 2'd1) mCtrl <= regWrData;
      if (mExp && mCtrl[1]) mPulse <= PUL;
      else if (mPulse != 0) mPulse <= mPulse - 1;
    end
  end

  function automatic logic [7:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mCnt;
      2'd1: return mCtrl;
      2'd2: return {mMouEn, mKbdEn, 1'b0, mStat, 4'b0000};
      default: return 8'd0;
    endcase
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic kbdPulse();
    kbdAct = 1'b1; @(negedge clk); kbdAct = 1'b0;
  endtask

  task automatic mousePulse();
    mouseAct = 1'b1; @(negedge clk); mouseAct = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd1357));
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    rdChk("R1", 2'd0, 8'h00);
    rdChk("R1", 2'd1, 8'h00);
    rdChk("R1", 2'd2, 8'h00);
    check("R1", {7'd0, kbRstN}, 8'h01);

    // R2 / R6 / R7 countdown, expiry, pulse
    wr(2'd1, 8'h02);
    wr(2'd0, 8'd3);
    rdChk("R2", 2'd0, 8'd3);
    step(7);  rdChk("R2", 2'd0, 8'd3);
    step(1);  rdChk("R2", 2'd0, 8'd2);
    step(16); rdChk("R6", 2'd0, 8'd0);
    rdChk("R6", 2'd2, 8'h10);
    check("R7", {7'd0, kbRstN}, 8'h00);
    step(2);  check("R7", {7'd0, kbRstN}, 8'h00);
    step(1);  check("R7", {7'd0, kbRstN}, 8'h01);
    step(20); rdChk("R6", 2'd0, 8'd0);

    // R8 sticky status
    wr(2'd2, 8'h10); rdChk("R8", 2'd2, 8'h10);
    wr(2'd0, 8'd5);  rdChk("R8", 2'd2, 8'h10);
    wr(2'd2, 8'h00); rdChk("R8", 2'd2, 8'h00);
    wr(2'd0, 8'd0);

    // R3 stop
    wr(2'd0, 8'd4); step(5); wr(2'd0, 8'd0);
    for (int i = 0; i < 100; i++) begin
      step(1);
      check("R3", {7'd0, kbRstN}, 8'h01);
    end
    rdChk("R3", 2'd0, 8'd0);
    rdChk("R3", 2'd2, 8'h00);

    // R4 keep-alive restarts prescaler
    wr(2'd0, 8'd2); step(6); wr(2'd0, 8'd2);
    step(7); rdChk("R4", 2'd0, 8'd2);
    step(1); rdChk("R4", 2'd0, 8'd1);
    wr(2'd0, 8'd0);

    // R7 no pulse when disabled
    wr(2'd1, 8'h00); wr(2'd0, 8'd1);
    for (int i = 0; i < 10; i++) begin
      step(1);
      check("R7", {7'd0, kbRstN}, 8'h01);
    end
    rdChk("R6", 2'd2, 8'h10);
    wr(2'd2, 8'h00);

    // R5 minute mode
    wr(2'd1, 8'h08); wr(2'd0, 8'd2);
    step(479); rdChk("R5", 2'd0, 8'd2);
    step(1);   rdChk("R5", 2'd0, 8'd1);
    wr(2'd0, 8'd0); wr(2'd1, 8'h00);

    // R9 keyboard reload, enabled then gated off
    wr(2'd1, 8'h04); wr(2'd2, 8'h40); wr(2'd0, 8'd5);
    step(20); rdChk("R9", 2'd0, 8'd3);
    kbdPulse();
    step(7); rdChk("R9", 2'd0, 8'd5);
    step(1); rdChk("R9", 2'd0, 8'd4);
    wr(2'd1, 8'h00); wr(2'd0, 8'd5);
    step(10); kbdPulse(); step(5);
    rdChk("R9", 2'd0, 8'd3);

    // R10 mouse reload, enabled then disabled
    wr(2'd2, 8'h80); wr(2'd0, 8'd5);
    step(10); mousePulse(); step(5);
    rdChk("R10", 2'd0, 8'd5);
    wr(2'd2, 8'h00); wr(2'd0, 8'd5);
    step(10); mousePulse(); step(5);
    rdChk("R10", 2'd0, 8'd3);

    // R11 activity while stopped
    wr(2'd2, 8'hC0); wr(2'd1, 8'h04); wr(2'd0, 8'd0);
    mousePulse(); kbdPulse(); step(2);
    rdChk("R11", 2'd0, 8'd0);

    // R12 / R1 register bits and unused address
    wr(2'd2, 8'hFF); rdChk("R12", 2'd2, 8'hC0);
    wr(2'd1, 8'hA5); rdChk("R12", 2'd1, 8'hA5);
    wr(2'd1, 8'h04);
    rdChk("R1", 2'd3, 8'h00);
    wr(2'd3, 8'hFF);
    rdChk("R1", 2'd3, 8'h00);
    rdChk("R1", 2'd1, 8'h04);
    rdChk("R1", 2'd0, 8'h00);
    rdChk("R1", 2'd2, 8'hC0);

    // random phase against the cycle model
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom % 16;
      case (op)
        0, 1: begin regWr = 1'b1; regAddr = 2'd0; regWrData = 8'($urandom % 4); end
        2: begin
          regWr = 1'b1; regAddr = 2'd1; regWrData = 8'($urandom) & 8'h0E;
          if ($urandom % 8 != 0) regWrData[3] = 1'b0;
        end
        3: begin regWr = 1'b1; regAddr = 2'd2; regWrData = 8'($urandom); end
        4: kbdAct = 1'b1;
        5: mouseAct = 1'b1;
        default: ;
      endcase
      @(negedge clk);
      regWr = 1'b0; kbdAct = 1'b0; mouseAct = 1'b0;
      regAddr = 2'($urandom);
      #1;
      check("R6", regRdData, modelRead(regAddr));
      check("R7", {7'd0, kbRstN}, {7'd0, (mPulse == 0)});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule